// File: doc/BRIEF.md
# Opto-Isolated Serial Register Access Port

This block is a two-wire asynchronous serial slave that lets a host read and write the registers of a larger device over a receive line and a transmit line. The low pin count makes it practical to place a pair of opto-isolators between the host and the device. Traffic moves in 11-bit character frames protected by odd parity. Every transaction opens with two command characters. These carry a 12-bit register address, a direction flag and a flag that requests a trailing checksum character.

A write sends two data characters for a 16-bit register or four for a 32-bit register, most significant byte first. An optional checksum character can follow the data. The block then issues one write strobe on its register-file port. A read strobes the register file once, right after the second command character. It then returns the data characters on the transmit line, followed by a checksum character if one was requested.

The bit rate is derived from the system clock. After reset it uses the slow divisor. Writing a key value to a write-only control register, held inside the block, switches between the slow and fast divisors. The serial port is only enabled when the select and serial-clock strap pins hold the right levels during reset.

Top module: `regacc_uart`

## Requirements
- R1: A character on either line is one low start bit, eight data bits sent least significant bit first, one parity bit, then one high stop bit. The parity bit makes the total count of ones among the nine data and parity bits odd.
- R2: One bit lasts SLOW_DIV clock cycles after reset (2560, which gives 4800 baud from 12.288 MHz). It lasts FAST_DIV cycles (104) once the fast rate is selected. Receive sampling runs at 16 ticks per bit from a fractional accumulator, so a divisor need not be a multiple of 16.
- R3: The first command character holds command bits 15:8 and the second holds bits 7:0. The register address is command bits 15:4. Bit 3 set means a read. Bit 2 set requests a checksum character.
- R4: A write carries four data characters when the register file reports a 32-bit register (reg_wide high), and two otherwise. Data is sent most significant byte first. After the last character (or after a valid checksum), reg_wr pulses for exactly one cycle with reg_addr and reg_wdata. 16-bit data is zero-extended to 32 bits.
- R5: The checksum character is the 8-bit sum, modulo 256, of every earlier character in the transaction. On a write, a checksum that does not match discards the write and returns the parser to waiting for a command.
- R6: Any received character with a parity error or a low stop bit discards the transaction in progress, and no write strobe follows.
- R7: A read gives one single-cycle reg_rd pulse with the decoded address. The block then transmits the 2 or 4 data bytes most significant first. If a checksum was requested, it then transmits the 8-bit sum of the two command characters and the data bytes.
- R8: A 16-bit write of 0x0052 to address BAUD_ADDR selects the fast rate. A write of 0x0000 to that address selects the slow rate, and any other value leaves the rate unchanged. Writes to BAUD_ADDR never reach the register-file port.
- R9: BAUD_ADDR is write-only. A read of it does not pulse reg_rd and returns 0x0000.
- R10: The port is enabled only if sel_pin is high and sclk_pin is low while rst is high. This choice holds until the next reset. When the port is disabled, rx is ignored, tx stays high and no strobe is issued.
- R11: A low pulse on rx that has ended by the middle of the start bit is not taken as a character.
- R12: reg_wr and reg_rd are never high together, and tx rests high outside a transmitted character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12.288 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| sel_pin | input | 1 | Select strap pin, sampled during reset |
| sclk_pin | input | 1 | Serial-clock strap pin, sampled during reset |
| rx | input | 1 | Serial receive line, idle high |
| tx | output | 1 | Serial transmit line, idle high |
| reg_addr | output | 12 | Register address of the current transaction |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_wdata | output | 32 | Write data, zero-extended for 16-bit registers |
| reg_wide | input | 1 | Register file reports reg_addr is a 32-bit register |
| reg_rdata | input | 32 | Register file read data, valid in the reg_rd cycle |

## Verification
The assertions assume that the strap pins hold steady through the reset pulse. They also assume that reg_wide and reg_rdata follow reg_addr combinationally, as a plain register file does. The bench meets both: it holds sel_pin and sclk_pin fixed for several cycles around each reset, and its register-file model answers from reg_addr in the same cycle. Every serial character the bench drives is timed from the divisor currently in force, and a new transaction starts only after the previous one has finished on both lines. The parser is therefore never handed overlapping traffic; the stray-low-pulse case is the one deliberate exception.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

    localparam int OVS     = 16;   // receive ticks per bit
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int FRAME_W = 11;

    typedef enum logic [3:0] {
        PS_CMD0,
        PS_CMD1,
        PS_WDAT,
        PS_WSUM,
        PS_COMMIT,
        PS_FETCH,
        PS_SEND,
        PS_SUM,
        PS_WAIT
    } pstate_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS
    } rxstate_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic              cs;
    } cmd_t;

    // parity bit that makes the count of ones odd
    function automatic logic odd_par(input logic [7:0] b);
        return ~(^b);
    endfunction

    function automatic cmd_t decode_cmd(input logic [7:0] hi, input logic [7:0] lo);
        cmd_t c;
        c.addr = {hi, lo[7:4]};
        c.rd   = lo[3];
        c.cs   = lo[2];
        return c;
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(input logic [7:0] b);
        return {1'b1, odd_par(b), b, 1'b0};
    endfunction

endpackage

// File: rtl/regacc_tick.sv
module regacc_tick
    import regacc_pkg::*;
#(
    parameter int SLOW_DIV = 2560,
    parameter int FAST_DIV = 104
) (
    input  logic clk,
    input  logic rst,
    input  logic fast,
    output logic tick
);
    localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int ACC_W   = $clog2(MAX_DIV + OVS) + 1;
    localparam logic [ACC_W-1:0] SLOW_L = ACC_W'(SLOW_DIV);
    localparam logic [ACC_W-1:0] FAST_L = ACC_W'(FAST_DIV);
    localparam logic [ACC_W-1:0] STEP_L = ACC_W'(OVS);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;
    logic [ACC_W-1:0] div;
    logic             fast_q;

    always_comb begin
        div     = fast ? FAST_L : SLOW_L;
        acc_sum = acc + STEP_L;
    end

    always_ff @(posedge clk) begin
        fast_q <= fast;
        if (rst || (fast != fast_q)) begin
            acc  <= '0;
            tick <= 1'b0;
        end else if (acc_sum >= div) begin
            acc  <= acc_sum - div;
            tick <= 1'b1;
        end else begin
            acc  <= acc_sum;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/regacc_rx.sv
module regacc_rx
    import regacc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       rx,
    input  logic       tick,
    output logic       vld,
    output logic [7:0] data,
    output logic       err
);
    localparam logic [3:0] MID_TICK  = 4'(OVS / 2 - 1);
    localparam logic [3:0] LAST_TICK = 4'(OVS - 1);
    localparam logic [3:0] STOP_IDX  = 4'd9;

    logic [1:0] sync;
    logic       rx_s;
    rxstate_t   st;
    logic [3:0] tcnt;
    logic [3:0] bidx;
    logic [8:0] sh;

    assign rx_s = sync[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync <= 2'b11;
            st   <= RX_IDLE;
            tcnt <= '0;
            bidx <= '0;
            sh   <= '0;
            vld  <= 1'b0;
            data <= '0;
            err  <= 1'b0;
        end else begin
            sync <= {sync[0], rx};
            vld  <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (en && !rx_s) begin
                        st   <= RX_START;
                        tcnt <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (tcnt == MID_TICK) begin
                            tcnt <= '0;
                            bidx <= '0;
                            st   <= rx_s ? RX_IDLE : RX_BITS;
                        end else begin
                            tcnt <= tcnt + 4'd1;
                        end
                    end
                end
                RX_BITS: begin
                    if (tick) begin
                        if (tcnt == LAST_TICK) begin
                            tcnt <= '0;
                            if (bidx == STOP_IDX) begin
                                vld  <= 1'b1;
                                data <= sh[7:0];
                                err  <= !rx_s || (sh[8] != odd_par(sh[7:0]));
                                st   <= RX_IDLE;
                            end else begin
                                sh   <= {rx_s, sh[8:1]};
                                bidx <= bidx + 4'd1;
                            end
                        end else begin
                            tcnt <= tcnt + 4'd1;
                        end
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/regacc_tx.sv
module regacc_tx
    import regacc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start,
    input  logic [7:0] data,
    output logic       busy,
    output logic       line
);
    localparam logic [3:0] LAST_TICK = 4'(OVS - 1);
    localparam logic [3:0] LAST_BIT  = 4'(FRAME_W - 1);

    logic [FRAME_W-1:0] sh;
    logic [3:0]         tcnt;
    logic [3:0]         bcnt;

    assign line = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            busy <= 1'b0;
            tcnt <= '0;
            bcnt <= '0;
        end else if (!busy) begin
            if (start) begin
                sh   <= build_frame(data);
                busy <= 1'b1;
                tcnt <= '0;
                bcnt <= '0;
            end
        end else if (tick) begin
            if (tcnt == LAST_TICK) begin
                tcnt <= '0;
                sh   <= {1'b1, sh[FRAME_W-1:1]};
                if (bcnt == LAST_BIT) busy <= 1'b0;
                else                  bcnt <= bcnt + 4'd1;
            end else begin
                tcnt <= tcnt + 4'd1;
            end
        end
    end
endmodule

// File: rtl/regacc_parser.sv
module regacc_parser
    import regacc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BAUD_ADDR = 12'h3C0,
    parameter logic [15:0]       FAST_KEY  = 16'h0052,
    parameter logic [15:0]       SLOW_KEY  = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_vld,
    input  logic [7:0]        rx_data,
    input  logic              rx_err,
    input  logic              tx_busy,
    output logic              tx_start,
    output logic [7:0]        tx_data,
    input  logic              reg_wide,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              fast
);
    pstate_t           st;
    cmd_t              cmd;
    logic [7:0]        hi;
    logic [7:0]        sum;
    logic [DATA_W-1:0] wbuf;
    logic [DATA_W-1:0] rbuf;
    logic [1:0]        cnt;
    logic              sum_done;

    logic              is_baud;
    logic              wide_eff;
    logic [1:0]        last_idx;
    logic [7:0]        rbyte;

    always_comb begin
        is_baud   = (cmd.addr == BAUD_ADDR);
        wide_eff  = reg_wide && !is_baud;
        last_idx  = wide_eff ? 2'd3 : 2'd1;
        rbyte     = rbuf[{cnt, 3'b000} +: 8];
        reg_addr  = cmd.addr;
        reg_wr    = (st == PS_COMMIT) && !is_baud;
        reg_rd    = (st == PS_FETCH) && !is_baud;
        reg_wdata = wide_eff ? wbuf : {16'h0000, wbuf[15:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= PS_CMD0;
            cmd      <= '0;
            hi       <= '0;
            sum      <= '0;
            wbuf     <= '0;
            rbuf     <= '0;
            cnt      <= '0;
            sum_done <= 1'b0;
            fast     <= 1'b0;
            tx_start <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_start <= 1'b0;
            case (st)
                PS_CMD0: begin
                    if (rx_vld && !rx_err) begin
                        hi  <= rx_data;
                        sum <= rx_data;
                        st  <= PS_CMD1;
                    end
                end
                PS_CMD1: begin
                    if (rx_vld) begin
                        if (rx_err) begin
                            st <= PS_CMD0;
                        end else begin
                            cmd      <= decode_cmd(hi, rx_data);
                            sum      <= sum + rx_data;
                            cnt      <= '0;
                            sum_done <= 1'b0;
                            st       <= rx_data[3] ? PS_FETCH : PS_WDAT;
                        end
                    end
                end
                PS_WDAT: begin
                    if (rx_vld) begin
                        if (rx_err) begin
                            st <= PS_CMD0;
                        end else begin
                            wbuf <= {wbuf[DATA_W-9:0], rx_data};
                            sum  <= sum + rx_data;
                            if (cnt == last_idx) st <= cmd.cs ? PS_WSUM : PS_COMMIT;
                            else                 cnt <= cnt + 2'd1;
                        end
                    end
                end
                PS_WSUM: begin
                    if (rx_vld) begin
                        st <= (!rx_err && (rx_data == sum)) ? PS_COMMIT : PS_CMD0;
                    end
                end
                PS_COMMIT: begin
                    if (is_baud) begin
                        if (wbuf[15:0] == FAST_KEY)      fast <= 1'b1;
                        else if (wbuf[15:0] == SLOW_KEY) fast <= 1'b0;
                    end
                    st <= PS_CMD0;
                end
                PS_FETCH: begin
                    if (is_baud)       rbuf <= '0;
                    else if (wide_eff) rbuf <= reg_rdata;
                    else               rbuf <= {16'h0000, reg_rdata[15:0]};
                    cnt <= last_idx;
                    st  <= PS_SEND;
                end
                PS_SEND: begin
                    tx_start <= 1'b1;
                    tx_data  <= rbyte;
                    sum      <= sum + rbyte;
                    st       <= PS_WAIT;
                end
                PS_SUM: begin
                    tx_start <= 1'b1;
                    tx_data  <= sum;
                    sum_done <= 1'b1;
                    st       <= PS_WAIT;
                end
                PS_WAIT: begin
                    if (!tx_start && !tx_busy) begin
                        if (sum_done) begin
                            st <= PS_CMD0;
                        end else if (cnt != 2'd0) begin
                            cnt <= cnt - 2'd1;
                            st  <= PS_SEND;
                        end else begin
                            st <= cmd.cs ? PS_SUM : PS_CMD0;
                        end
                    end
                end
                default: st <= PS_CMD0;
            endcase
        end
    end
endmodule

// File: rtl/regacc_uart.sv
module regacc_uart
    import regacc_pkg::*;
#(
    parameter int                SLOW_DIV  = 2560,
    parameter int                FAST_DIV  = 104,
    parameter logic [ADDR_W-1:0] BAUD_ADDR = 12'h3C0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_pin,
    input  logic              sclk_pin,
    input  logic              rx,
    output logic              tx,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wide,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic       uart_en;
    logic       fast;
    logic       tick;
    logic       rx_vld;
    logic [7:0] rx_data;
    logic       rx_err;
    logic       tx_start;
    logic [7:0] tx_data;
    logic       tx_busy;
    logic       tx_line;

    // strap sampling: captured only while reset is asserted
    always_ff @(posedge clk) begin
        if (rst) uart_en <= sel_pin && !sclk_pin;
    end

    assign tx = uart_en ? tx_line : 1'b1;

    regacc_tick #(
        .SLOW_DIV(SLOW_DIV),
        .FAST_DIV(FAST_DIV)
    ) u_tick (
        .clk (clk),
        .rst (rst),
        .fast(fast),
        .tick(tick)
    );

    regacc_rx u_rx (
        .clk (clk),
        .rst (rst),
        .en  (uart_en),
        .rx  (rx),
        .tick(tick),
        .vld (rx_vld),
        .data(rx_data),
        .err (rx_err)
    );

    regacc_parser #(
        .BAUD_ADDR(BAUD_ADDR)
    ) u_parser (
        .clk      (clk),
        .rst      (rst),
        .rx_vld   (rx_vld),
        .rx_data  (rx_data),
        .rx_err   (rx_err),
        .tx_busy  (tx_busy),
        .tx_start (tx_start),
        .tx_data  (tx_data),
        .reg_wide (reg_wide),
        .reg_rdata(reg_rdata),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .fast     (fast)
    );

    regacc_tx u_tx (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .start(tx_start),
        .data (tx_data),
        .busy (tx_busy),
        .line (tx_line)
    );
endmodule

// File: rtl/regacc_uart_chk.sv
module regacc_uart_chk
    import regacc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BAUD_ADDR = 12'h3C0
) (
    input logic              clk,
    input logic              rst,
    input logic              tx,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              uart_en,
    input logic              tx_busy
);
    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    // R4
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    // R7
    rd_single_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd);

    // R8
    baud_wr_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> (reg_addr != BAUD_ADDR));

    // R9
    baud_rd_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd |-> (reg_addr != BAUD_ADDR));

    // R10
    sel_locked_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(uart_en));

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !uart_en |-> (tx && !reg_wr && !reg_rd));

    // R12
    tx_rest_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> tx);
endmodule

bind regacc_uart regacc_uart_chk #(.BAUD_ADDR(BAUD_ADDR)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tx      (tx),
    .reg_wr  (reg_wr),
    .reg_rd  (reg_rd),
    .reg_addr(reg_addr),
    .uart_en (uart_en),
    .tx_busy (tx_busy)
);

// File: tb/sim_regacc_uart.sv
module sim_regacc_uart;
    localparam int CLK_PERIOD = 10;
    localparam int SLOW       = 208;
    localparam int FAST       = 56;
    localparam logic [11:0] BAUD_A = 12'h3C0;
    localparam int WATCHDOG   = 180000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_pin = 1'b1;
    logic        sclk_pin = 1'b0;
    logic        rx = 1'b1;
    logic        tx;
    logic [11:0] reg_addr;
    logic        reg_wr;
    logic        reg_rd;
    logic [31:0] reg_wdata;
    logic        reg_wide;
    logic [31:0] reg_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    int bitc   = SLOW;

    logic [31:0] rf     [16];   // register file seen by the block
    logic [31:0] ref_rf [16];   // bench expectation of its contents
    logic [43:0] exp_wr [$];    // {addr, data}
    logic [11:0] exp_rd [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign reg_wide  = reg_addr[11];
    assign reg_rdata = rf[reg_addr[3:0]];

    regacc_uart #(
        .SLOW_DIV (SLOW),
        .FAST_DIV (FAST),
        .BAUD_ADDR(BAUD_A)
    ) u0 (
        .clk      (clk),
        .rst      (rst),
        .sel_pin  (sel_pin),
        .sclk_pin (sclk_pin),
        .rx       (rx),
        .tx       (tx),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_wdata(reg_wdata),
        .reg_wide (reg_wide),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-clock model comparison of the register-file strobes
    always @(negedge clk) begin
        if (!rst) begin
            if (reg_wr) begin
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R4 unexpected write strobe", {20'h0, reg_addr}, 32'h0);
                end else begin
                    logic [43:0] e;
                    e = exp_wr.pop_front();
                    chk(reg_addr == e[43:32], "R3 write address", {20'h0, reg_addr}, {20'h0, e[43:32]});
                    chk(reg_wdata == e[31:0], "R4 write data", reg_wdata, e[31:0]);
                end
                rf[reg_addr[3:0]] = reg_wdata;
            end
            if (reg_rd) begin
                if (exp_rd.size() == 0) begin
                    chk(1'b0, "R7 unexpected read strobe", {20'h0, reg_addr}, 32'h0);
                end else begin
                    logic [11:0] a;
                    a = exp_rd.pop_front();
                    chk(reg_addr == a, "R7 read address", {20'h0, reg_addr}, {20'h0, a});
                end
            end
        end
    end

    task automatic wait_bits(input int n);
        repeat (n * bitc) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit bad_par);
        rx = 1'b0;
        repeat (bitc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (bitc) @(negedge clk);
        end
        rx = (~^b) ^ bad_par;
        repeat (bitc) @(negedge clk);
        rx = 1'b1;
        repeat (bitc) @(negedge clk);
    endtask

    task automatic recv_frame(output logic [7:0] b, output bit ok);
        logic p;
        while (tx !== 1'b0) @(negedge clk);
        repeat (bitc / 2) @(negedge clk);
        ok = (tx == 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (bitc) @(negedge clk);
            b[i] = tx;
        end
        repeat (bitc) @(negedge clk);
        p = tx;
        ok = ok && (p == ~^b);
        repeat (bitc) @(negedge clk);
        ok = ok && (tx == 1'b1);
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d, input bit cs,
                            input bit bad_cs, input bit bad_par, input bit expect_it);
        logic [7:0] f [7];
        int   n;
        int   nd;
        logic [7:0] s;
        nd = a[11] ? 4 : 2;
        f[0] = a[11:4];
        f[1] = {a[3:0], 1'b0, cs, 2'b00};
        for (int i = 0; i < nd; i++) f[2 + i] = d[(nd - 1 - i) * 8 +: 8];
        n = 2 + nd;
        s = 8'h00;
        for (int i = 0; i < n; i++) s = s + f[i];
        if (cs) begin
            f[n] = bad_cs ? (s ^ 8'h5A) : s;
            n++;
        end
        if (expect_it) begin
            logic [31:0] dz;
            dz = a[11] ? d : {16'h0, d[15:0]};
            exp_wr.push_back({a, dz});
            if (a != BAUD_A) ref_rf[a[3:0]] = dz;
        end
        for (int i = 0; i < n; i++) send_frame(f[i], bad_par && (i == n - 1));
        wait_bits(2);
        chk(exp_wr.size() == 0, "R4 write strobe count", exp_wr.size(), 0);
    endtask

    task automatic do_read(input logic [11:0] a, input bit cs, input logic [31:0] exp_d, input string req);
        logic [7:0] c0;
        logic [7:0] c1;
        logic [7:0] s;
        int   nd;
        nd = (a[11] && a != BAUD_A) ? 4 : 2;
        c0 = a[11:4];
        c1 = {a[3:0], 1'b1, cs, 2'b00};
        s  = c0 + c1;
        if (a != BAUD_A) exp_rd.push_back(a);
        fork
            begin
                send_frame(c0, 1'b0);
                send_frame(c1, 1'b0);
            end
            begin
                for (int i = 0; i < nd; i++) begin
                    logic [7:0] b;
                    bit ok;
                    logic [7:0] e;
                    recv_frame(b, ok);
                    e = exp_d[(nd - 1 - i) * 8 +: 8];
                    chk(ok, "R1 transmitted frame format", {24'h0, b}, {24'h0, e});
                    chk(b == e, req, {24'h0, b}, {24'h0, e});
                    s = s + e;
                end
                if (cs) begin
                    logic [7:0] b;
                    bit ok;
                    recv_frame(b, ok);
                    chk(ok && b == s, "R7 read checksum", {24'h0, b}, {24'h0, s});
                end
            end
        join
        wait_bits(2);
        chk(exp_rd.size() == 0, "R7 read strobe count", exp_rd.size(), 0);
    endtask

    task automatic do_reset(input logic sel, input logic sck);
        @(negedge clk);
        sel_pin = sel;
        sclk_pin = sck;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", WATCHDOG, WATCHDOG);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            rf[i] = 32'hC0DE_0000 + i;
            ref_rf[i] = rf[i];
        end
        do_reset(1'b1, 1'b0);

        // reset state
        chk(tx == 1'b1, "R12 tx idle after reset", {31'h0, tx}, 1);
        chk(reg_wr == 1'b0, "R4 no write after reset", {31'h0, reg_wr}, 0);
        chk(reg_rd == 1'b0, "R7 no read after reset", {31'h0, reg_rd}, 0);

        // R3 R4: 16-bit write, no checksum, slow rate (R2)
        do_write(12'h003, 32'h0000_BEEF, 1'b0, 1'b0, 1'b0, 1'b1);
        // R4 R5: 32-bit write with correct checksum
        do_write(12'h805, 32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b1);
        // R5: wrong checksum drops the write
        do_write(12'h806, 32'hDEAD_0001, 1'b1, 1'b1, 1'b0, 1'b0);
        // R6: parity error on the last data character drops the write
        do_write(12'h004, 32'h0000_9999, 1'b0, 1'b0, 1'b1, 1'b0);

        // R11: short low pulse must not start a character
        @(negedge clk);
        rx = 1'b0;
        repeat (bitc / 4) @(negedge clk);
        rx = 1'b1;
        wait_bits(2);
        do_write(12'h004, 32'h0000_1357, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(rf[4] == 32'h0000_1357, "R11 write after glitch lands", rf[4], 32'h0000_1357);

        // R7: 16-bit read with checksum
        do_read(12'h003, 1'b1, ref_rf[3], "R7 read16 data");
        // R7: 32-bit read without checksum
        do_read(12'h806, 1'b0, ref_rf[6], "R5 R7 read32 data after dropped write");

        // R8: non-key value leaves rate slow; write not forwarded
        do_write(BAUD_A, 32'h0000_0011, 1'b0, 1'b0, 1'b0, 1'b0);
        do_read(12'h003, 1'b0, ref_rf[3], "R8 rate kept by non-key value");
        // R8: key selects the fast rate
        do_write(BAUD_A, 32'h0000_0052, 1'b0, 1'b0, 1'b0, 1'b0);
        bitc = FAST;
        wait_bits(2);
        do_read(12'h805, 1'b1, ref_rf[5], "R2 R8 read32 at fast rate");
        // R9: write-only register reads as zero, no read strobe
        do_read(BAUD_A, 1'b0, 32'h0, "R9 baud register reads zero");
        // R8: zero returns to slow rate
        do_write(BAUD_A, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
        bitc = SLOW;
        wait_bits(2);
        do_write(12'h007, 32'h0000_00AA, 1'b1, 1'b0, 1'b0, 1'b1);
        chk(rf[7] == 32'h0000_00AA, "R8 slow write after switch back", rf[7], 32'h0000_00AA);

        // R10: strap pins deselect the port
        do_reset(1'b0, 1'b0);
        do_write(12'h001, 32'h0000_4444, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(rf[1] == ref_rf[1], "R10 disabled port ignores rx", rf[1], ref_rf[1]);
        chk(tx == 1'b1, "R10 disabled port tx high", {31'h0, tx}, 1);

        finish_run();
    end
endmodule